// File: doc/BRIEF.md
# Reset, Powerup and Bus-Mode Controller

This block is the power-state keeper of a serial-controlled device. It watches an active-low reset pin and the pair of control bits that software writes together (an enable bit and a disable bit). From these it decides whether the device is held in reset, powered down, running normally, partly powered down, or working through an internal powerdown sequence. It reports the current state and the readback value of both control bits.

When reset is released, the block samples two strap pins once and keeps the serial bus mode they select, either two-wire or three-wire, until the next reset. When software asks for a full powerdown, the block counts a fixed number of cycles. At the end of that count it clears the enable bit by itself and sends a one-cycle strobe that tells the data register beside it to clear to zero, so the register is empty before the next enable.

State encoding on `state_o`: 0 INACTIVE (held in reset), 1 PWRDN (powered down, bus usable), 2 UP (normal operation), 3 SEQ (powerdown sequence running), 4 PARTIAL (partial powerdown, undesirable). Transitions: INACTIVE→PWRDN on the first clock after reset release; PWRDN→UP and PARTIAL→UP on a write of enable=1, disable=0; UP→SEQ on a write of 1/1; UP→PARTIAL on a write with enable=0; SEQ→PWRDN when the sequence count ends; any state→INACTIVE while reset is low.

Top module: `pmc_top`

## Requirements
- R1: While `rst_n` is low, `state_o`=0, both readbacks are 0, `bus_mode_o`=0, `bus_active_o`=0 and `clr_o`=0.
- R2: On the first rising clock after `rst_n` goes high, the state becomes PWRDN (1) and `bus_mode_o` takes the strap decode: `strap_i`=2'b01 gives two-wire (1), 2'b10 gives three-wire (2).
- R3: `strap_i` values 2'b00 and 2'b11 latch the invalid mode (0), and `bus_active_o` then stays 0. With a valid mode, `bus_active_o` is 1 in every state except INACTIVE.
- R4: A write (`wr_i`=1) of enable=1, disable=0 in PWRDN or PARTIAL moves to UP on the next edge. UP reads back enable=1, disable=0.
- R5: A write of 1/1 in UP moves to SEQ. SEQ lasts exactly PD_CYCLES cycles and reads back 1/1. The state then becomes PWRDN, which reads back 0/0.
- R6: Writes during SEQ are ignored. The sequence length and the following PWRDN state do not change.
- R7: `clr_o` is high for exactly one cycle, the last cycle of SEQ, and at no other time.
- R8: A write with enable=0 in UP moves to PARTIAL. PARTIAL reads back enable=0 and the disable value from that write.
- R9: PARTIAL is left only by a write of 1/0 or by reset. Writes of 1/1 or enable=0 keep PARTIAL.
- R10: In PWRDN, writes of 1/1 or enable=0 keep PWRDN with readback 0/0.
- R11: Strap changes after reset release do not change `bus_mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin, asynchronous assert |
| strap_i | input | 2 | Bus-mode strap pins, sampled on reset release |
| wr_i | input | 1 | Control-bit write strobe |
| en_i | input | 1 | Enable bit value being written |
| dis_i | input | 1 | Disable bit value being written |
| state_o | output | 3 | Current power state code |
| en_rb_o | output | 1 | Enable bit readback |
| dis_rb_o | output | 1 | Disable bit readback |
| bus_mode_o | output | 2 | Latched bus mode (0 invalid, 1 two-wire, 2 three-wire) |
| bus_active_o | output | 1 | Serial bus usable |
| clr_o | output | 1 | One-cycle data-register clear strobe |

## Verification
A write made before a rising edge shows up in the state and readbacks right after that edge. The bus mode is set by the first edge after reset release. The clear strobe rises PD_CYCLES-1 edges after the edge that enters SEQ, and PWRDN follows one edge after that. The bench drives inputs and compares outputs only on falling edges. Its cycle model updates on each rising edge from the inputs held across that edge, so every compare sees exactly the cycle the design is due to show.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [2:0] {
        ST_INACTIVE = 3'd0,
        ST_PWRDN    = 3'd1,
        ST_UP       = 3'd2,
        ST_SEQ      = 3'd3,
        ST_PARTIAL  = 3'd4
    } pmc_state_e;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_TWO   = 2'd1,
        MODE_THREE = 2'd2
    } pmc_mode_e;
endpackage

// File: rtl/pmc_strap_decode.sv
module pmc_strap_decode
    import pmc_pkg::*;
(
    input  logic [1:0] strap_i,
    output pmc_mode_e  mode_o
);
    always_comb begin
        unique case (strap_i)
            2'b01:   mode_o = MODE_TWO;
            2'b10:   mode_o = MODE_THREE;
            default: mode_o = MODE_NONE;
        endcase
    end
endmodule

// File: rtl/pmc_seq_timer.sv
module pmc_seq_timer #(
    parameter int PD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);
    localparam int CW = (PD_CYCLES > 1) ? $clog2(PD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(PD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run_i) cnt_q <= '0;
        else if (!last_o) cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int PD_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_i,
    input  logic       wr_i,
    input  logic       en_i,
    input  logic       dis_i,
    output logic [2:0] state_o,
    output logic       en_rb_o,
    output logic       dis_rb_o,
    output logic [1:0] bus_mode_o,
    output logic       bus_active_o,
    output logic       clr_o
);
    pmc_state_e state_q, state_d;
    pmc_mode_e  mode_q, strap_mode;
    logic       dis_q;
    logic       seq_last;

    pmc_strap_decode u_dec (
        .strap_i (strap_i),
        .mode_o  (strap_mode)
    );

    pmc_seq_timer #(.PD_CYCLES(PD_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_SEQ),
        .last_o (seq_last)
    );

    logic wr_up, wr_down;
    assign wr_up   = wr_i && en_i && !dis_i;
    assign wr_down = wr_i && en_i && dis_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INACTIVE: state_d = ST_PWRDN;
            ST_PWRDN:    if (wr_up) state_d = ST_UP;
            ST_UP: begin
                if (wr_down)          state_d = ST_SEQ;
                else if (wr_i && !en_i) state_d = ST_PARTIAL;
            end
            ST_SEQ:      if (seq_last) state_d = ST_PWRDN;
            ST_PARTIAL:  if (wr_up) state_d = ST_UP;
            default:     state_d = ST_INACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INACTIVE;
            mode_q  <= MODE_NONE;
            dis_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_INACTIVE) mode_q <= strap_mode;
            if (state_q == ST_UP && wr_i && !en_i) dis_q <= dis_i;
        end
    end

    always_comb begin
        en_rb_o  = 1'b0;
        dis_rb_o = 1'b0;
        clr_o    = 1'b0;
        unique case (state_q)
            ST_INACTIVE, ST_PWRDN: ;
            ST_UP:      en_rb_o = 1'b1;
            ST_SEQ: begin
                en_rb_o  = 1'b1;
                dis_rb_o = 1'b1;
                clr_o    = seq_last;
            end
            ST_PARTIAL: dis_rb_o = dis_q;
            default: ;
        endcase
        state_o      = state_q;
        bus_mode_o   = mode_q;
        bus_active_o = (state_q != ST_INACTIVE) && (mode_q != MODE_NONE);
    end
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_i,
    input logic       en_i,
    input logic       dis_i,
    input logic [2:0] state_o,
    input logic [1:0] bus_mode_o,
    input logic       bus_active_o,
    input logic       clr_o
);
    // R3
    invalid_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode_o == 2'd0) |-> !bus_active_o);
    // R7
    clr_then_pwrdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> (state_o == 3'd1) && !clr_o);
    // R7
    pwrdn_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == 3'd3 && state_o == 3'd1) |-> $past(clr_o));
    // R6
    seq_exit_only_pwrdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3) |=> (state_o == 3'd3 || state_o == 3'd1));
    // R9
    partial_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == 3'd4 && state_o != 3'd4) |->
            ($past(wr_i && en_i && !dis_i) && state_o == 3'd2));
    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) != 3'd0 && state_o != 3'd0) |-> $stable(bus_mode_o));
endmodule

bind pmc_top pmc_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (wr_i),
    .en_i         (en_i),
    .dis_i        (dis_i),
    .state_o      (state_o),
    .bus_mode_o   (bus_mode_o),
    .bus_active_o (bus_active_o),
    .clr_o        (clr_o)
);

// File: tb/tb_pmc_top.sv
module tb_pmc_top;
    localparam int PD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] strap_i = 2'b01;
    logic wr_i = 1'b0, en_i = 1'b0, dis_i = 1'b0;
    logic [2:0] state_o;
    logic en_rb_o, dis_rb_o, bus_active_o, clr_o;
    logic [1:0] bus_mode_o;

    int n_tests = 0, n_fail = 0;
    int m_st = 0, m_cnt = 0, m_mode = 0;
    logic m_dis = 1'b0;

    always #2 clk = ~clk;

    pmc_top #(.PD_CYCLES(PD)) dut (.*);

    function automatic int dec_strap(logic [1:0] s);
        return (s == 2'b01) ? 1 : (s == 2'b10) ? 2 : 0;
    endfunction

    task automatic model_edge();
        if (!rst_n) begin m_st = 0; m_cnt = 0; m_mode = 0; m_dis = 0; return; end
        case (m_st)
            0: begin m_st = 1; m_mode = dec_strap(strap_i); end
            1: if (wr_i && en_i && !dis_i) m_st = 2;
            2: if (wr_i && en_i && dis_i) begin m_st = 3; m_cnt = 0; end
               else if (wr_i && !en_i) begin m_st = 4; m_dis = dis_i; end
            3: if (m_cnt == PD-1) m_st = 1; else m_cnt++;
            4: if (wr_i && en_i && !dis_i) m_st = 2;
            default: m_st = 0;
        endcase
    endtask

    task automatic cmp(string tag);
        logic [8:0] act, exp;
        logic e_en, e_dis, e_clr, e_act;
        e_en  = (m_st == 2 || m_st == 3);
        e_dis = (m_st == 3) || (m_st == 4 && m_dis);
        e_clr = (m_st == 3 && m_cnt == PD-1);
        e_act = (m_st != 0 && m_mode != 0);
        act = {state_o, en_rb_o, dis_rb_o, bus_mode_o, bus_active_o, clr_o};
        exp = {3'(m_st), e_en, e_dis, 2'(m_mode), e_act, e_clr};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {st,en,dis,mode,act,clr} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(logic w, logic e, logic d, string tag);
        wr_i = w; en_i = e; dis_i = d;
        @(posedge clk); model_edge();
        @(negedge clk); wr_i = 0;
        cmp(tag);
    endtask

    task automatic do_reset(logic [1:0] s, string tag);
        @(negedge clk); rst_n = 0; strap_i = s; model_edge();
        #1 cmp(tag);
        @(negedge clk); rst_n = 1;
        @(posedge clk); model_edge();
        @(negedge clk); cmp(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++; n_tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk); cmp("R1");
        // R1 R2 two-wire
        do_reset(2'b01, "R2");
        strap_i = 2'b10; step(0, 0, 0, "R11");
        // R10 writes in PWRDN that keep it
        step(1, 1, 1, "R10"); step(1, 0, 1, "R10");
        // R4
        step(1, 1, 0, "R4");
        // R5 R6 R7
        step(1, 1, 1, "R5");
        for (int i = 0; i < PD - 1; i++) step(1, $urandom_range(1), $urandom_range(1), "R6");
        step(0, 0, 0, "R7");
        // R8 R9
        step(1, 1, 0, "R4"); step(1, 0, 1, "R8");
        step(1, 1, 1, "R9"); step(1, 0, 0, "R9"); step(1, 1, 0, "R9");
        // R3 invalid and three-wire straps
        do_reset(2'b11, "R3"); do_reset(2'b00, "R3"); do_reset(2'b10, "R2");
        // constrained random
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(299) == 0) do_reset(2'($urandom_range(3)), "R1");
            else begin
                strap_i = 2'($urandom_range(3));
                step($urandom_range(2) == 0, $urandom_range(3) != 0, $urandom_range(1), "RND");
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule